// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block is the eight-bit status register of an asynchronous serial port. It keeps the handshake flags between software and the two datapaths: transmit buffer empty, transmit complete and receive buffer full. It also keeps the three receive error flags, the multiprocessor bit captured with the last received character, and the multiprocessor bit that software wants sent with the next character.

The transmitter and the receiver report events as single-cycle pulses. These are a reception finishing (with its stop-bit and parity verdicts and its multiprocessor bit), a buffer-to-shifter load, transmit being disabled, and the last bit of a character leaving the line. Software accesses to the data buffers arrive as side-effect pulses.

Software reads the register through a read strobe. It can drop a flag only by writing 0 to it after a read that returned it as 1, or through the data-buffer side effects. When a hardware set and a clear meet on one flag in the same clock, the set wins.

Top module: `sio_status_reg`

## Requirements
- R1: After reset `rd_data` is 8'h84: transmit-empty (bit 7) and transmit-done (bit 2) are 1, every other bit is 0.
- R2: `rd_data` bit 7 is `tx_empty`, bit 6 `rx_full`, bit 5 `err_overrun`, bit 4 `err_frame`, bit 3 `err_parity`, bit 2 `tx_done`, bit 1 `mpb_rx`, bit 0 `mpb_tx`, and these match the flag outputs in every cycle.
- R3: A register write never sets bits 7..3 and never changes bits 2 or 1. Bit 0 (`mpb_tx`) takes `wr_data[0]` on every write.
- R4: A write with 0 in one of bits 7..3 clears that flag only if a read since the previous write returned it as 1. Any write forgets all such read records.
- R5: A completed reception with good stop and parity bits, while `rx_full` is 0, sets `rx_full`. A `rdr_read` pulse clears it.
- R6: A completed reception while `rx_full` is 1 sets `err_overrun` and does not set `rx_full` again.
- R7: A completed reception with a bad stop bit sets `err_frame`, one with a bad parity bit sets `err_parity`, and neither sets `rx_full`.
- R8: `tx_empty` is set by `tdr_load` or `tx_disable` and cleared by `tdr_write`.
- R9: `tx_last_bit` sets `tx_done` only while `tx_empty` is 1. `tx_done` is cleared by `tdr_write` or by a handshake clear of `tx_empty`.
- R10: When a set event and a clear (software or side effect) hit the same flag in one clock, the flag ends up 1.
- R11: `mpb_rx` takes `rx_mp_bit` on every completed reception, good or bad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | Software read of the status register |
| wr_stb | input | 1 | Software write of the status register |
| wr_data | input | REG_W | Write data |
| rd_data | output | REG_W | Current register contents |
| rx_done | input | 1 | Reception finished (pulse) |
| rx_stop_bad | input | 1 | Stop bit sampled as 0, valid with `rx_done` |
| rx_par_bad | input | 1 | Parity mismatch, valid with `rx_done` |
| rx_mp_bit | input | 1 | Received multiprocessor bit, valid with `rx_done` |
| rdr_read | input | 1 | Software read of the receive data buffer |
| tdr_write | input | 1 | Software write of the transmit data buffer |
| tdr_load | input | 1 | Transmit buffer moved into the shifter |
| tx_disable | input | 1 | Transmit enable being cleared |
| tx_last_bit | input | 1 | Last bit of a character sent |
| tx_empty | output | 1 | Transmit buffer empty flag |
| rx_full | output | 1 | Receive buffer full flag |
| err_overrun | output | 1 | Overrun error flag |
| err_frame | output | 1 | Framing error flag |
| err_parity | output | 1 | Parity error flag |
| tx_done | output | 1 | Transmission complete flag |
| mpb_rx | output | 1 | Last received multiprocessor bit |
| mpb_tx | output | 1 | Multiprocessor bit to transmit |

## Verification
The embedded properties watch the single-edge consequences of every event on every cycle. They cover overrun versus buffer-full on a completed reception, the set of `tx_done` only from a last bit while the buffer is empty, the capture of both multiprocessor bits, the loss of all read records after any write, and set-over-clear priority in each flag cell. Only the bench's scenarios can show the multi-step handshake: that a write of 0 clears nothing until a read has returned the flag as 1, and that a second write after the read clears nothing. They also show that a handshake clear of the empty flag also drops `tx_done`, that an errored reception leaves the buffer-full flag alone, and the full byte image after long event sequences.

// File: rtl/sio_stat_pkg.sv
package sio_stat_pkg;

   // register geometry
   localparam int unsigned STAT_W  = 8;
   localparam int unsigned CLR_N   = 5;               // software-clearable flags
   localparam int unsigned CLR_LSB = STAT_W - CLR_N;  // lowest clearable bit

   // bit positions (software decodes these)
   localparam int unsigned B_TXE = 7;
   localparam int unsigned B_RXF = 6;
   localparam int unsigned B_OVR = 5;
   localparam int unsigned B_FRM = 4;
   localparam int unsigned B_PAR = 3;
   localparam int unsigned B_TXD = 2;
   localparam int unsigned B_MPR = 1;
   localparam int unsigned B_MPT = 0;

   // indices inside the clearable-flag vector
   localparam int unsigned K_TXE = B_TXE - CLR_LSB;
   localparam int unsigned K_RXF = B_RXF - CLR_LSB;
   localparam int unsigned K_OVR = B_OVR - CLR_LSB;
   localparam int unsigned K_FRM = B_FRM - CLR_LSB;
   localparam int unsigned K_PAR = B_PAR - CLR_LSB;

   localparam logic [STAT_W-1:0] STAT_RST = 8'h84;

   // per-flag control pair
   typedef struct packed {
      logic set;
      logic clr;
   } flag_ctl_t;

endpackage

// File: rtl/sio_sticky_flag.sv
module sio_sticky_flag #(
   parameter bit RST_VAL  = 1'b0,
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);

   generate
      if (SET_WINS) begin : g_set_pri
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q_o <= RST_VAL;
            else if (set_i) q_o <= 1'b1;
            else if (clr_i) q_o <= 1'b0;
         end

         // R10
         set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i |=> q_o);
      end else begin : g_clr_pri
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q_o <= RST_VAL;
            else if (clr_i) q_o <= 1'b0;
            else if (set_i) q_o <= 1'b1;
         end
      end
   endgenerate

   // R4
   clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);

   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !set_i) |=> $stable(q_o));

endmodule

// File: rtl/sio_clear_arm.sv
module sio_clear_arm #(
   parameter int unsigned N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rd_stb,
   input  logic         wr_stb,
   input  logic [N-1:0] flags_i,
   output logic [N-1:0] arm_o
);

   if (N == 0) begin : g_bad_n
      $error("sio_clear_arm: N must be non-zero");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       arm_o <= '0;
      else if (wr_stb)  arm_o <= '0;
      else if (rd_stb)  arm_o <= arm_o | flags_i;
   end

   // R4
   arm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> (arm_o == '0));

   // R4
   arm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> ((arm_o & ~($past(arm_o) | ($past(flags_i) & {N{$past(rd_stb)}}))) == '0));

endmodule

// File: rtl/sio_status_reg.sv
module sio_status_reg
   import sio_stat_pkg::*;
#(
   parameter int unsigned REG_W    = 8,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_stb,
   input  logic             wr_stb,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   input  logic             rx_done,
   input  logic             rx_stop_bad,
   input  logic             rx_par_bad,
   input  logic             rx_mp_bit,
   input  logic             rdr_read,
   input  logic             tdr_write,
   input  logic             tdr_load,
   input  logic             tx_disable,
   input  logic             tx_last_bit,
   output logic             tx_empty,
   output logic             rx_full,
   output logic             err_overrun,
   output logic             err_frame,
   output logic             err_parity,
   output logic             tx_done,
   output logic             mpb_rx,
   output logic             mpb_tx
);

   localparam int unsigned NCLR = CLR_N;
   localparam int unsigned LSBC = REG_W - NCLR;

   if (REG_W != STAT_W) begin : g_bad_width
      $error("sio_status_reg: REG_W must equal the status layout width");
   end

   logic [NCLR-1:0] clr_q;
   logic [NCLR-1:0] armed;
   logic [NCLR-1:0] sw_clr;
   flag_ctl_t [NCLR-1:0] ctl;
   logic            rx_ok;
   logic            unused_wr_bits;

   assign unused_wr_bits = ^wr_data[LSBC-1:1];

   // software handshake clear: write 0 to an armed flag
   assign sw_clr = {NCLR{wr_stb}} & ~wr_data[REG_W-1:LSBC] & armed;
   assign rx_ok  = rx_done & ~rx_stop_bad & ~rx_par_bad;

   always_comb begin
      ctl[K_TXE].set = tdr_load | tx_disable;
      ctl[K_TXE].clr = tdr_write | sw_clr[K_TXE];
      ctl[K_RXF].set = rx_ok & ~clr_q[K_RXF];
      ctl[K_RXF].clr = rdr_read | sw_clr[K_RXF];
      ctl[K_OVR].set = rx_done & clr_q[K_RXF];
      ctl[K_OVR].clr = sw_clr[K_OVR];
      ctl[K_FRM].set = rx_done & rx_stop_bad;
      ctl[K_FRM].clr = sw_clr[K_FRM];
      ctl[K_PAR].set = rx_done & rx_par_bad;
      ctl[K_PAR].clr = sw_clr[K_PAR];
   end

   sio_clear_arm #(.N(NCLR)) u_arm (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_stb  (rd_stb),
      .wr_stb  (wr_stb),
      .flags_i (clr_q),
      .arm_o   (armed)
   );

   for (genvar k = 0; k < NCLR; k++) begin : g_flag
      sio_sticky_flag #(
         .RST_VAL  (STAT_RST[k+LSBC]),
         .SET_WINS (SET_WINS)
      ) u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (ctl[k].set),
         .clr_i (ctl[k].clr),
         .q_o   (clr_q[k])
      );
   end

   // transmit-complete: read-only, tied to the empty flag's handshake
   sio_sticky_flag #(
      .RST_VAL  (STAT_RST[B_TXD]),
      .SET_WINS (SET_WINS)
   ) u_txdone (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (tx_last_bit & clr_q[K_TXE]),
      .clr_i (tdr_write | sw_clr[K_TXE]),
      .q_o   (tx_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mpb_rx <= STAT_RST[B_MPR];
         mpb_tx <= STAT_RST[B_MPT];
      end else begin
         if (rx_done) mpb_rx <= rx_mp_bit;
         if (wr_stb)  mpb_tx <= wr_data[B_MPT];
      end
   end

   assign tx_empty    = clr_q[K_TXE];
   assign rx_full     = clr_q[K_RXF];
   assign err_overrun = clr_q[K_OVR];
   assign err_frame   = clr_q[K_FRM];
   assign err_parity  = clr_q[K_PAR];

   always_comb begin
      rd_data        = '0;
      rd_data[B_TXE] = tx_empty;
      rd_data[B_RXF] = rx_full;
      rd_data[B_OVR] = err_overrun;
      rd_data[B_FRM] = err_frame;
      rd_data[B_PAR] = err_parity;
      rd_data[B_TXD] = tx_done;
      rd_data[B_MPR] = mpb_rx;
      rd_data[B_MPT] = mpb_tx;
   end

   // R3
   mpb_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> (mpb_tx == $past(wr_data[B_MPT])));

   // R11
   mpb_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> (mpb_rx == $past(rx_mp_bit)));

   // R7
   bad_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && (rx_stop_bad || rx_par_bad) && !rx_full) |=> !rx_full);

   // R9
   tx_done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_done) |-> $past(tx_last_bit && tx_empty));

   if (SET_WINS) begin : g_pri_chk
      // R6
      overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rx_done && rx_full) |=> err_overrun);

      // R5
      rx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rx_done && !rx_stop_bad && !rx_par_bad && !rx_full) |=> rx_full);

      // R9
      tx_done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (tx_last_bit && tx_empty) |=> tx_done);

      // R8
      tx_empty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (tdr_load || tx_disable) |=> tx_empty);
   end

endmodule

// File: tb/test_sio_status_reg.sv
`timescale 1ns/1ps
module test_sio_status_reg;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       rd_stb, wr_stb;
   logic [7:0] wr_data, rd_data;
   logic       rx_done, rx_stop_bad, rx_par_bad, rx_mp_bit;
   logic       rdr_read, tdr_write, tdr_load, tx_disable, tx_last_bit;
   logic       tx_empty, rx_full, err_overrun, err_frame, err_parity;
   logic       tx_done, mpb_rx, mpb_tx;

   int  n_chk = 0;
   int  n_err = 0;
   bit  finished = 1'b0;

   always #2.5 clk = ~clk;

   sio_status_reg i_sio_status_reg (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
      .wr_data(wr_data), .rd_data(rd_data),
      .rx_done(rx_done), .rx_stop_bad(rx_stop_bad), .rx_par_bad(rx_par_bad),
      .rx_mp_bit(rx_mp_bit), .rdr_read(rdr_read), .tdr_write(tdr_write),
      .tdr_load(tdr_load), .tx_disable(tx_disable), .tx_last_bit(tx_last_bit),
      .tx_empty(tx_empty), .rx_full(rx_full), .err_overrun(err_overrun),
      .err_frame(err_frame), .err_parity(err_parity), .tx_done(tx_done),
      .mpb_rx(mpb_rx), .mpb_tx(mpb_tx)
   );

   // vector: {rd, wr, wr_data[7:0], events[8:0], expected[7:0]}
   // events: [8]rx_done [7]stop_bad [6]par_bad [5]mp_bit [4]rdr_read
   //         [3]tdr_write [2]tdr_load [1]tx_disable [0]tx_last_bit
   localparam int NV = 26;
   localparam logic [26:0] VEC [NV] = '{
      {2'b00, 8'h00, 9'b100100000, 8'hC6},  //  0 R5 R11 good rx, mp=1
      {2'b00, 8'h00, 9'b100000000, 8'hE4},  //  1 R6 rx while full
      {2'b01, 8'h00, 9'b000000000, 8'hE4},  //  2 R4 write 0 with no read
      {2'b10, 8'h00, 9'b000000000, 8'hE4},  //  3 R4 read arms
      {2'b01, 8'hBF, 9'b000000000, 8'hA5},  //  4 R4 R3 clear rx_full only
      {2'b01, 8'h00, 9'b000000000, 8'hA4},  //  5 R4 records gone
      {2'b00, 8'h00, 9'b110100000, 8'hB6},  //  6 R7 stop bad
      {2'b00, 8'h00, 9'b101000000, 8'hBC},  //  7 R7 parity bad
      {2'b00, 8'h00, 9'b000001000, 8'h38},  //  8 R8 R9 tdr write
      {2'b00, 8'h00, 9'b000000001, 8'h38},  //  9 R9 last bit, not empty
      {2'b00, 8'h00, 9'b000000100, 8'hB8},  // 10 R8 load
      {2'b00, 8'h00, 9'b000000001, 8'hBC},  // 11 R9 last bit, empty
      {2'b10, 8'h00, 9'b000000000, 8'hBC},  // 12 R4 read arms
      {2'b01, 8'h40, 9'b000000000, 8'h00},  // 13 R4 R9 handshake clears
      {2'b00, 8'h00, 9'b000000010, 8'h80},  // 14 R8 tx disable
      {2'b00, 8'h00, 9'b100000000, 8'hC0},  // 15 R5
      {2'b00, 8'h00, 9'b000010000, 8'h80},  // 16 R5 data read clears
      {2'b00, 8'h00, 9'b100000000, 8'hC0},  // 17 R5
      {2'b10, 8'h00, 9'b000000000, 8'hC0},  // 18 R4
      {2'b01, 8'hBF, 9'b100000000, 8'hA1},  // 19 R6 overrun from current flag
      {2'b10, 8'h00, 9'b000000000, 8'hA1},  // 20 R4
      {2'b01, 8'hC0, 9'b110000000, 8'h90},  // 21 R7 R4
      {2'b10, 8'h00, 9'b000000000, 8'h90},  // 22 R4
      {2'b01, 8'h80, 9'b110000000, 8'h90},  // 23 R10 frame set beats clear
      {2'b00, 8'h00, 9'b100010000, 8'hD0},  // 24 R10 full set beats data read
      {2'b00, 8'h00, 9'b000001010, 8'hD0}   // 25 R10 empty set beats tdr write
   };

   localparam string REQ [NV] = '{
      "R5 R11", "R6", "R4", "R4", "R4 R3", "R4", "R7", "R7", "R8 R9", "R9",
      "R8", "R9", "R4", "R4 R9", "R8", "R5", "R5", "R5", "R4", "R6",
      "R4", "R7", "R4", "R10", "R10", "R10"
   };

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      rd_stb = 0; wr_stb = 0; wr_data = 8'h00;
      rx_done = 0; rx_stop_bad = 0; rx_par_bad = 0; rx_mp_bit = 0;
      rdr_read = 0; tdr_write = 0; tdr_load = 0; tx_disable = 0; tx_last_bit = 0;
   endtask

   function automatic logic [7:0] flag_ports();
      return {tx_empty, rx_full, err_overrun, err_frame, err_parity, tx_done, mpb_rx, mpb_tx};
   endfunction

   task automatic summary_and_end();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=running expected=finished");
         summary_and_end();
      end
   end

   initial begin
      rst_n = 1'b0;
      idle_inputs();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check8("R1 reset image", rd_data, 8'h84);
      check8("R2 reset ports", flag_ports(), 8'h84);

      for (int i = 0; i < NV; i++) begin
         {rd_stb, wr_stb, wr_data,
          rx_done, rx_stop_bad, rx_par_bad, rx_mp_bit, rdr_read,
          tdr_write, tdr_load, tx_disable, tx_last_bit} = VEC[i][26:8];
         @(negedge clk);
         idle_inputs();
         check8($sformatf("%s vector %0d", REQ[i], i), rd_data, VEC[i][7:0]);
         check8($sformatf("R2 ports vector %0d", i), flag_ports(), VEC[i][7:0]);
      end

      // R1: reset in the middle of a run restores the image
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check8("R1 mid-run reset", rd_data, 8'h84);

      // R10: last bit and tdr write together while empty: done stays set
      tdr_write = 1; tx_last_bit = 1;
      @(negedge clk);
      idle_inputs();
      check8("R10 done set beats clear", rd_data, 8'h04);

      // R3: write of ones leaves bits 7..1 as they are, bit 0 follows data
      wr_stb = 1; wr_data = 8'hFF;
      @(negedge clk);
      idle_inputs();
      check8("R3 write ones", rd_data, 8'h05);

      // R4: read then clear with no armed flags and empty=0 stays 0
      rd_stb = 1;
      @(negedge clk);
      idle_inputs();
      wr_stb = 1; wr_data = 8'h00;
      @(negedge clk);
      idle_inputs();
      check8("R4 nothing armed", rd_data, 8'h04);

      finished = 1'b1;
      summary_and_end();
   end

endmodule